// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks, every clock cycle, which of the warp slots resident in one compute unit gets to issue its next instruction. A warp is a group of 32 threads that share one instruction stream, so a chosen warp issues for all of its lanes at once. For each slot the block keeps one bit that says whether the warp is stalled. A stall report from any lane of a warp marks the whole warp stalled, and it stays stalled until a wake pulse for that slot arrives. A slot can be picked only if its valid input is high and it is not stalled.

Slots are served in round-robin order. The search starts at the slot after the last warp that issued, so no warp waits forever. Moving from one warp to a different one costs a fixed context-switch penalty of `SWITCH_BUBBLES` cycles, which must be 1 or 2. During those cycles nothing issues. A warp that is the only eligible one keeps issuing every cycle and pays no penalty. When no slot is eligible, the block raises an idle flag so the surrounding logic can lower power.

The block holds 32 slots by default, which fills a unit of 1024 resident threads. There is exactly one scheduler instance, and it chooses only among its own slots.

Top module: `warp_issue_scheduler`

## Requirements
- R1: After reset every slot is ready (not stalled) and no warp has issued yet. With no slot valid, `idle` is 1 and `issueValid` is 0. The first issue after reset goes to the lowest-numbered eligible slot, with no bubble before it.
- R2: A `stallEvt` pulse for slot w in cycle t keeps w from issuing in every cycle from t+1 until a wake has taken effect.
- R3: A `wakeEvt` pulse for a stalled slot w in cycle t makes w eligible from cycle t+1. If `stallEvt` and `wakeEvt` for the same slot are high in the same cycle, the stall wins.
- R4: A slot whose `slotValid` bit is 0 is never issued, whatever its stall state.
- R5: A new warp is chosen round-robin. The choice is the first eligible slot found by searching upward, with wrap-around, from the slot just after the last issued warp. The last issued warp itself is searched last.
- R6: When the chosen warp differs from the last issued warp, `issueValid` stays 0 for exactly `SWITCH_BUBBLES` cycles, the first of them being the cycle of the choice. The chosen warp then issues, provided it is still eligible.
- R7: When the last issued warp is the only eligible slot, it issues in consecutive cycles with no bubble.
- R8: `idle` is 1 exactly in the cycles in which no slot is both valid and not stalled. It reacts in the same cycle that eligibility changes. While `idle` is 1, `issueValid` is 0.
- R9: If the chosen warp stops being eligible during its switch bubbles, the block does not issue it. After the bubbles it chooses again under R5 from the last issued warp, and pays the R6 penalty again if that new choice is also a different warp.
- R10: A stall reported for a warp in a cycle in which that warp issues does not cancel that issue. Stall state is sampled at the start of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | NUM_SLOTS | Level: slot holds a live warp |
| stallEvt | input | NUM_SLOTS | Pulse: some lane of the slot's warp stalled |
| wakeEvt | input | NUM_SLOTS | Pulse: the slot's stall condition has cleared |
| issueValid | output | 1 | An instruction issues for `issueWarp` in this cycle |
| issueWarp | output | $clog2(NUM_SLOTS) | Slot index of the issuing warp; meaningful only while `issueValid` is 1 |
| idle | output | 1 | No slot is eligible; power may be reduced |

## Verification
Two things can happen to one slot in the same cycle. A stall and a wake can both land on it, and a stall can land on the very warp that is issuing. The bench drives both cases directly. It then checks that the slot stays stalled, and that the issue in that cycle still goes out. A loss of eligibility can also coincide with a pending context switch. The bench drops the target warp's valid bit inside its bubble window and checks that the choice is made again rather than issued blindly. A random phase mixes all these coincidences, and every cycle is compared against a model written from the requirements.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Strobes from the control FSM to the datapath, one set per cycle.
  typedef struct packed {
    logic issueNow;       // an instruction issues this cycle
    logic fromTarget;     // issue the latched switch target, not the fresh pick
    logic captureTarget;  // latch the fresh pick and start a context switch
  } schedStrobes_t;

endpackage

// File: rtl/warp_slot_state.sv
module warp_slot_state #(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  logic [NUM_SLOTS-1:0] stallEvt,
  input  logic [NUM_SLOTS-1:0] wakeEvt,
  output logic [NUM_SLOTS-1:0] eligible
);

  logic [NUM_SLOTS-1:0] stalled;

  // One stall flag per slot; a stall report beats a wake in the same cycle.
  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stalled[gi] <= 1'b0;
      end else if (stallEvt[gi]) begin
        stalled[gi] <= 1'b1;
      end else if (wakeEvt[gi]) begin
        stalled[gi] <= 1'b0;
      end
    end

    assign eligible[gi] = slotValid[gi] & ~stalled[gi];
  end

endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker #(
  parameter int NUM_SLOTS = 32,
  parameter int ID_W      = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] eligible,
  input  logic [ID_W-1:0]      base,
  input  logic                 baseValid,
  output logic                 anyHit,
  output logic [ID_W-1:0]      pickIdx
);

  int startIdx;

  always_comb begin
    anyHit  = |eligible;
    pickIdx = '0;
    if (baseValid) startIdx = int'(base);
    else           startIdx = NUM_SLOTS - 1;
    // Walk from farthest to nearest offset so the nearest eligible slot wins.
    for (int k = NUM_SLOTS; k >= 1; k--) begin
      automatic int idx = startIdx + k;
      if (idx >= NUM_SLOTS) idx = idx - NUM_SLOTS;
      if (eligible[idx[ID_W-1:0]]) pickIdx = idx[ID_W-1:0];
    end
  end

endmodule

// File: rtl/warp_sched_datapath.sv
module warp_sched_datapath
  import warp_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ID_W      = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  logic [NUM_SLOTS-1:0] stallEvt,
  input  logic [NUM_SLOTS-1:0] wakeEvt,
  input  schedStrobes_t        strobes,
  output logic                 anyElig,
  output logic                 pickNoSwitch,
  output logic                 targetElig,
  output logic [ID_W-1:0]      issueWarp
);

  logic [NUM_SLOTS-1:0] eligible;
  logic [ID_W-1:0]      pick;
  logic [ID_W-1:0]      prevWarp;
  logic                 havePrev;
  logic [ID_W-1:0]      targetWarp;

  warp_slot_state #(.NUM_SLOTS(NUM_SLOTS)) uState (
    .clk       (clk),
    .rstN      (rstN),
    .slotValid (slotValid),
    .stallEvt  (stallEvt),
    .wakeEvt   (wakeEvt),
    .eligible  (eligible)
  );

  warp_rr_picker #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) uPick (
    .eligible  (eligible),
    .base      (prevWarp),
    .baseValid (havePrev),
    .anyHit    (anyElig),
    .pickIdx   (pick)
  );

  // Round robin puts the previous warp last, so the pick equals it only
  // when it is the sole eligible slot.
  assign pickNoSwitch = !havePrev || (pick == prevWarp);
  assign targetElig   = eligible[targetWarp];
  assign issueWarp    = strobes.fromTarget ? targetWarp : pick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWarp   <= '0;
      havePrev   <= 1'b0;
      targetWarp <= '0;
    end else begin
      if (strobes.issueNow) begin
        prevWarp <= issueWarp;
        havePrev <= 1'b1;
      end
      if (strobes.captureTarget) targetWarp <= pick;
    end
  end

endmodule

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int SWITCH_BUBBLES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          anyElig,
  input  logic          pickNoSwitch,
  input  logic          targetElig,
  output schedStrobes_t strobes,
  output logic          issueValid
);

  localparam int LEFT_W    = $clog2(SWITCH_BUBBLES + 1);
  localparam int LEFT_INIT = (SWITCH_BUBBLES >= 2) ? SWITCH_BUBBLES - 2 : 0;

  logic              switching;
  logic              armed;
  logic [LEFT_W-1:0] left;

  always_comb begin
    strobes = '0;
    if (!switching) begin
      if (armed && targetElig) begin
        strobes.issueNow   = 1'b1;
        strobes.fromTarget = 1'b1;
      end else if (anyElig) begin
        if (pickNoSwitch) strobes.issueNow      = 1'b1;
        else              strobes.captureTarget = 1'b1;
      end
    end
  end

  assign issueValid = strobes.issueNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      switching <= 1'b0;
      armed     <= 1'b0;
      left      <= '0;
    end else if (switching) begin
      if (left == '0) begin
        switching <= 1'b0;
        armed     <= 1'b1;
      end else begin
        left <= left - 1'b1;
      end
    end else begin
      armed <= 1'b0;
      if (strobes.captureTarget) begin
        // The cycle of the choice is the first bubble.
        if (SWITCH_BUBBLES == 1) begin
          armed <= 1'b1;
        end else begin
          switching <= 1'b1;
          left      <= LEFT_W'(LEFT_INIT);
        end
      end
    end
  end

endmodule

// File: rtl/warp_issue_scheduler.sv
module warp_issue_scheduler
  import warp_sched_pkg::*;
#(
  parameter int NUM_SLOTS      = 32,
  parameter int SWITCH_BUBBLES = 2,
  localparam int ID_W          = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  logic [NUM_SLOTS-1:0] stallEvt,
  input  logic [NUM_SLOTS-1:0] wakeEvt,
  output logic                 issueValid,
  output logic [ID_W-1:0]      issueWarp,
  output logic                 idle
);

  schedStrobes_t strobes;
  logic          anyElig;
  logic          pickNoSwitch;
  logic          targetElig;

  warp_sched_datapath #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .slotValid    (slotValid),
    .stallEvt     (stallEvt),
    .wakeEvt      (wakeEvt),
    .strobes      (strobes),
    .anyElig      (anyElig),
    .pickNoSwitch (pickNoSwitch),
    .targetElig   (targetElig),
    .issueWarp    (issueWarp)
  );

  warp_sched_ctrl #(.SWITCH_BUBBLES(SWITCH_BUBBLES)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .anyElig      (anyElig),
    .pickNoSwitch (pickNoSwitch),
    .targetElig   (targetElig),
    .strobes      (strobes),
    .issueValid   (issueValid)
  );

  assign idle = ~anyElig;

endmodule

// File: rtl/warp_issue_scheduler_chk.sv
module warp_issue_scheduler_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int ID_W      = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] slotValid,
  input logic [NUM_SLOTS-1:0] stallEvt,
  input logic [NUM_SLOTS-1:0] wakeEvt,
  input logic                 issueValid,
  input logic [ID_W-1:0]      issueWarp,
  input logic                 idle
);

  logic [NUM_SLOTS-1:0] shadowStalled;
  logic                 prevIssued;
  logic [ID_W-1:0]      lastWarp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowStalled <= '0;
      prevIssued    <= 1'b0;
      lastWarp      <= '0;
    end else begin
      shadowStalled <= stallEvt | (shadowStalled & ~wakeEvt);
      prevIssued    <= issueValid;
      lastWarp      <= issueWarp;
    end
  end

  AST_NO_INVALID_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> slotValid[issueWarp]); // R4

  AST_NO_STALLED_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !shadowStalled[issueWarp]); // R2

  AST_IDLE_TRACKS_ELIG: assert property (@(posedge clk) disable iff (!rstN)
    idle == ((slotValid & ~shadowStalled) == '0)); // R8

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !issueValid); // R8

  AST_SWITCH_HAS_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && prevIssued) |-> (issueWarp == lastWarp)); // R6

endmodule

bind warp_issue_scheduler warp_issue_scheduler_chk #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .slotValid  (slotValid),
  .stallEvt   (stallEvt),
  .wakeEvt    (wakeEvt),
  .issueValid (issueValid),
  .issueWarp  (issueWarp),
  .idle       (idle)
);

// File: tb/warp_issue_scheduler_test.sv
module warp_issue_scheduler_test;

  localparam int N          = 32;
  localparam int BUB        = 2;
  localparam int ID_W       = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN;
  logic [N-1:0]    slotValid, stallEvt, wakeEvt;
  logic            issueValid;
  logic [ID_W-1:0] issueWarp;
  logic            idle;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_scheduler #(.NUM_SLOTS(N), .SWITCH_BUBBLES(BUB)) uut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .stallEvt(stallEvt),
    .wakeEvt(wakeEvt), .issueValid(issueValid), .issueWarp(issueWarp), .idle(idle)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  // Reference model state, built from the requirements.
  bit [N-1:0] mStalled;
  int mPrev, mTarget, mLeft;
  bit mHavePrev, mArmed, mSwitching;
  int nPrev, nTarget, nLeft;
  bit nHavePrev, nArmed, nSwitching;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rrPick(input bit [N-1:0] e, input int base, input bit hv);
    int start = hv ? base : N - 1;
    for (int k = 1; k <= N; k++) begin
      int idx = (start + k) % N;
      if (e[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic modelReset();
    mStalled = '0; mPrev = 0; mTarget = 0; mLeft = 0;
    mHavePrev = 0; mArmed = 0; mSwitching = 0;
  endtask

  // One cycle: compare outputs against the model, then advance the model.
  task automatic step(input string tag);
    bit [N-1:0] e;
    bit expV, expIdle;
    int expW, p;
    #1;
    e = slotValid & ~mStalled;
    expIdle = (e == '0);
    expV = 0; expW = 0;
    nPrev = mPrev; nHavePrev = mHavePrev; nTarget = mTarget;
    nLeft = mLeft; nArmed = mArmed; nSwitching = mSwitching;
    if (mSwitching) begin
      if (mLeft == 0) begin nSwitching = 0; nArmed = 1; end
      else nLeft = mLeft - 1;
    end else if (mArmed && e[mTarget]) begin
      expV = 1; expW = mTarget; nPrev = mTarget; nHavePrev = 1; nArmed = 0;
    end else begin
      nArmed = 0;
      if (!expIdle) begin
        p = rrPick(e, mPrev, mHavePrev);
        if (!mHavePrev || p == mPrev) begin
          expV = 1; expW = p; nPrev = p; nHavePrev = 1;
        end else begin
          nTarget = p;
          if (BUB == 1) nArmed = 1;
          else begin nSwitching = 1; nLeft = BUB - 2; end
        end
      end
    end
    check(issueValid == expV, tag, "issueValid", int'(issueValid), int'(expV));
    check(idle == expIdle, tag, "idle", int'(idle), int'(expIdle));
    if (expV) check(int'(issueWarp) == expW, tag, "issueWarp", int'(issueWarp), expW);
    @(posedge clk);
    mStalled = stallEvt | (mStalled & ~wakeEvt);
    mPrev = nPrev; mHavePrev = nHavePrev; mTarget = nTarget;
    mLeft = nLeft; mArmed = nArmed; mSwitching = nSwitching;
    @(negedge clk);
    stallEvt = '0; wakeEvt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; slotValid = '0; stallEvt = '0; wakeEvt = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state with nothing valid.
    #1;
    check(idle == 1'b1, "R1", "idle after reset", int'(idle), 1);
    check(issueValid == 1'b0, "R1", "issueValid after reset", int'(issueValid), 0);
    step("R1");

    // R1 / R5: several slots valid, first issue is lowest slot, no bubble.
    slotValid = 32'h0000_0101;
    step("R1");
    // R6: switch from 0 to 8 pays the bubbles, then back.
    repeat (8) step("R6");

    // R7: only slot 8 valid, issues back to back.
    slotValid = 32'h0000_0100;
    repeat (6) step("R7");

    // R10: stall reported on the issuing warp; this cycle still issues.
    #1;
    check(issueValid && issueWarp == 8, "R10", "issue before stall", int'(issueWarp), 8);
    stallEvt[8] = 1'b1;
    step("R10");
    // R2 / R8: now stalled, nothing else eligible.
    repeat (3) step("R2");

    // R3: stall and wake together, stall wins.
    stallEvt[8] = 1'b1; wakeEvt[8] = 1'b1;
    step("R3");
    repeat (2) step("R3");
    // R8: wake clears it; idle drops the following cycle.
    wakeEvt[8] = 1'b1;
    step("R8");
    repeat (3) step("R8");

    // R4: invalid slot that is not stalled is never issued.
    slotValid = 32'h0000_0000;
    repeat (3) step("R4");
    slotValid = 32'h8000_0000;
    repeat (3) step("R4");

    // R9: target drops out inside the bubble window.
    slotValid = 32'h8000_0004;
    step("R9");
    slotValid = 32'h8000_0000;
    repeat (6) step("R9");

    // R5: round-robin order over many slots.
    slotValid = 32'hF0F0_0F0F;
    repeat (60) step("R5");

    // Random mixing of stalls, wakes, and valid changes.
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 8 == 0) slotValid[$urandom % N] ^= 1'b1;
      for (int s = 0; s < N; s++) begin
        if ($urandom % 24 == 0) stallEvt[s] = 1'b1;
        if ($urandom % 6 == 0)  wakeEvt[s]  = 1'b1;
      end
      step("R5");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule